// File: doc/BRIEF.md
# PWM Dead-Band Generator

This block takes one modulated control signal and turns it into a complementary pair of gate drives for a half-H bridge: a high-side drive and a low-side drive. While the block is enabled, only the primary input is used. The high-side drive follows it, and the low-side drive follows its inverse. Each drive turns on only after its own programmable number of clock cycles. During that gap neither switch conducts, so shoot-through cannot happen.

When the block is disabled, it acts as a plain registered pass-through for the two incoming signals. A generator that already produces two independent waveforms can then drive the bridge directly. Every path, delayed or bypassed, has the same one-cycle register latency. Both delays are cycle counts that are sampled live, so the controlling logic can change them between periods.

Top module: `pwm_deadband`

## Requirements
- R1: While reset is asserted, both drives are low.
- R2: With `en_i` low, `hs_o` equals `pwm_a_i` and `ls_o` equals `pwm_b_i`, each as sampled at the previous clock edge. In this mode the two drives may be high together.
- R3: With `en_i` high, `pwm_b_i` has no effect on either drive.
- R4: With `en_i` high, `hs_o` goes high only after `pwm_a_i` has been sampled high at `rise_dly_i`+1 consecutive edges. A count of 0 therefore gives the same one-cycle latency as the bypass.
- R5: With `en_i` high, `ls_o` goes high only after `pwm_a_i` has been sampled low at `fall_dly_i`+1 consecutive edges.
- R6: Turn-off has no delay. With `en_i` high, `hs_o` is low one cycle after `pwm_a_i` is sampled low, and `ls_o` is low one cycle after `pwm_a_i` is sampled high.
- R7: A pulse (or a gap) that is shorter than its delay never reaches the output. The count starts again from zero at the next edge of `pwm_a_i`.
- R8: In any cycle that follows an edge at which `en_i` was high, `hs_o` and `ls_o` are never high together.
- R9: Both delays are 12-bit unsigned counts, and the largest value, 4095, delays turn-on by exactly 4095 cycles beyond the bypass latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 1: dead-band mode, 0: registered pass-through |
| rise_dly_i | input | 12 | Turn-on delay of the high-side drive, in cycles |
| fall_dly_i | input | 12 | Turn-on delay of the low-side drive, in cycles |
| pwm_a_i | input | 1 | Primary modulated input |
| pwm_b_i | input | 1 | Secondary input, used only in pass-through |
| hs_o | output | 1 | High-side drive |
| ls_o | output | 1 | Low-side drive |

## Verification
The bench uses the default 12-bit delay width. The cycle table runs with turn-on delays of 2 and 1, which exposes each counting step, the pulse shorter than its delay and the restart. Directed tests then set both delays to 0, to show the zero-delay latency, and to 4095, so that the full range of the counter is reached within the run. During the 4095-cycle wait the secondary input toggles on every cycle, which shows that it is ignored over a long window.

// File: rtl/db_pkg.sv
package db_pkg;
    typedef enum int {
        LEG_HS = 0,
        LEG_LS = 1
    } leg_e;
    localparam int NUM_LEGS = 2;
endpackage

// File: rtl/db_edge_delay.sv
module db_edge_delay #(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             out_o
);
    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             out;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!level_i) begin
            st_d.cnt = '0;
            st_d.out = 1'b0;
        end else if (st_q.cnt >= dly_i) begin
            st_d.out = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = st_q.out;
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DLY_W-1:0] rise_dly_i,
    input  logic [DLY_W-1:0] fall_dly_i,
    input  logic             pwm_a_i,
    input  logic             pwm_b_i,
    output logic             hs_o,
    output logic             ls_o
);
    import db_pkg::*;

    typedef struct packed {
        logic en;
        logic a;
        logic b;
    } byp_t;

    byp_t byp_d, byp_q;
    logic [NUM_LEGS-1:0] leg_out;

    always_comb begin
        byp_d    = byp_q;
        byp_d.en = en_i;
        byp_d.a  = pwm_a_i;
        byp_d.b  = pwm_b_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byp_q <= '0;
        else        byp_q <= byp_d;
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        logic             lvl;
        logic [DLY_W-1:0] dly;
        if (g == LEG_HS) begin : g_hs
            assign lvl = en_i & pwm_a_i;
            assign dly = rise_dly_i;
        end else begin : g_ls
            assign lvl = en_i & ~pwm_a_i;
            assign dly = fall_dly_i;
        end
        db_edge_delay #(.DLY_W(DLY_W)) u_dly (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (lvl),
            .dly_i   (dly),
            .out_o   (leg_out[g])
        );
    end

    assign hs_o = byp_q.en ? leg_out[LEG_HS] : byp_q.a;
    assign ls_o = byp_q.en ? leg_out[LEG_LS] : byp_q.b;
endmodule

// File: rtl/pwm_deadband_chk.sv
module pwm_deadband_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic pwm_a_i,
    input logic pwm_b_i,
    input logic hs_o,
    input logic ls_o
);
    p_reset_low_r1: assert property (@(negedge clk) !rst_n |-> (!hs_o && !ls_o));

    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en_i)) |-> (hs_o == $past(pwm_a_i) && ls_o == $past(pwm_b_i)));

    p_hs_fast_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_i) && !$past(pwm_a_i)) |-> !hs_o);

    p_ls_fast_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_i) && $past(pwm_a_i)) |-> !ls_o);

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_i)) |-> !(hs_o && ls_o));
endmodule

bind pwm_deadband pwm_deadband_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .pwm_a_i (pwm_a_i),
    .pwm_b_i (pwm_b_i),
    .hs_o    (hs_o),
    .ls_o    (ls_o)
);

// File: tb/pwm_deadband_tb.sv
module pwm_deadband_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [11:0] rise_dly = '0;
    logic [11:0] fall_dly = '0;
    logic        a = 1'b0;
    logic        b = 1'b0;
    logic        hs, ls;

    int n_chk = 0;
    int n_bad = 0;
    int overlap = 0;
    logic en_last = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    pwm_deadband u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .rise_dly_i(rise_dly),
        .fall_dly_i(fall_dly), .pwm_a_i(a), .pwm_b_i(b), .hs_o(hs), .ls_o(ls)
    );

    // R8 monitor: enable as sampled at the last edge
    always @(posedge clk) en_last <= en;
    always @(negedge clk) if (rst_n && en_last && hs && ls) overlap++;

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {hs,ls} actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // bits: {en, a, b, exp_hs, exp_ls}; rise delay 2, fall delay 1
    localparam logic [4:0] ROWS [20] = '{
        5'b01010, 5'b00101, 5'b01111, 5'b00000,
        5'b10100, 5'b10001,
        5'b11100, 5'b11000, 5'b11110, 5'b11010,
        5'b10100, 5'b10001,
        5'b11000, 5'b11100, 5'b10100, 5'b11000, 5'b11000, 5'b11010,
        5'b01010, 5'b00101
    };

    function automatic string row_tag(int i);
        if (i < 4 || i >= 18) return "R2 bypass";
        if (i < 6)  return "R5 low-side delay";
        if (i < 10) return "R4 high-side delay, R3 b ignored";
        if (i < 12) return "R6 immediate turn-off";
        return "R7 short pulse restart";
    endfunction

    initial begin
        int wait_n;
        int b_hit;
        repeat (3) @(negedge clk);
        check("R1 reset", {hs, ls}, 2'b00);
        a = 1'b1; b = 1'b1;
        @(negedge clk);
        check("R1 reset held", {hs, ls}, 2'b00);
        a = 1'b0; b = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        rise_dly = 12'd2; fall_dly = 12'd1;
        for (int i = 0; i < 20; i++) begin
            {en, a, b} = ROWS[i][4:2];
            @(negedge clk);
            check(row_tag(i), {hs, ls}, ROWS[i][1:0]);
        end

        // R4/R5 zero delay
        en = 1'b0; a = 1'b0; b = 1'b0; @(negedge clk);
        rise_dly = 12'd0; fall_dly = 12'd0; en = 1'b1; a = 1'b1;
        @(negedge clk);
        check("R4 zero delay", {hs, ls}, 2'b10);
        a = 1'b0; @(negedge clk);
        check("R5 zero delay", {hs, ls}, 2'b01);

        // R9 maximum delay, R3 with b toggling throughout
        rise_dly = 12'd4095; fall_dly = 12'd4095;
        a = 1'b1; wait_n = 0; b_hit = 0;
        while (!hs && wait_n < 5000) begin
            b = ~b;
            @(negedge clk);
            wait_n++;
            if (ls) b_hit++;
        end
        check("R9 max rise delay", wait_n[1:0] == 2'b00 && wait_n == 4096 ? 2'b11 : 2'b00, 2'b11);
        check("R3 b ignored over long wait", {b_hit != 0, 1'b0}, 2'b00);
        a = 1'b0; @(negedge clk);
        check("R6 high-side off at once", {hs, ls}, 2'b00);
        wait_n = 1;
        while (!ls && wait_n < 5000) begin
            @(negedge clk);
            wait_n++;
        end
        check("R9 max fall delay", {wait_n == 4096, 1'b0}, 2'b10);

        check("R8 no overlap", {overlap != 0, 1'b0}, 2'b00);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule